// File: doc/BRIEF.md
# Dock Predicate and Flag Update Unit

This unit holds the A, B and C condition flags of a dock and decides, for each instruction presented to it, whether that instruction is skipped. The skip decision comes from a one-hot mask: every mask bit names one condition on A, B or the externally supplied D flag, and the instruction is skipped as soon as any named condition is true. A set-flags instruction rewrites A and B together. Each new value is the OR of literals chosen by a 6-bit selector, and every literal is read from the flag values held before the update.

Each completed move rewrites C. The source of the new value depends on whether the dock is an input or an output dock and on three move control bits. When no source applies, C is marked invalid. The unit also reports two programming errors. One is a set-flags that reads C in the instruction directly after a move. The other is a move that can be torpedoed but enables neither the token input nor the data input.

The surrounding dock decodes instructions and keeps the loop counters. It sends one strobe for each instruction kind: predicate evaluation, set-flags, move completion, and the completion of any other instruction.

Top module: `dock_flag_unit`

## Requirements
- R1: Predicate mask bit layout: bit0 skip if A=1, bit1 skip if A=0, bit2 skip if B=1, bit3 skip if B=0, bit4 skip if D=1, bit5 skip if D=0. `dec_skip` is the OR of the selected conditions and is presented with `dec_valid` one cycle after `pred_valid`. For example, mask 6'b001001 executes only when B=1 and A=0.
- R2: An all-zero predicate mask never skips.
- R3: Selector literal layout, used by both `setf_sel_a` and `setf_sel_b`: bit0 A, bit1 not A, bit2 B, bit3 not B, bit4 C, bit5 not C. On `setf_valid`, A and B each take the OR of their selected literals, all read from the pre-update flags. The new values appear one cycle later.
- R4: An all-zero selector field clears that flag. The abort encoding (A field 6'b000001, B field 6'b000100) leaves A and B unchanged.
- R5: On `mv_done` at an output dock (`mv_is_output`=1) with `mv_dc`=1, C takes `ship_bit` and `c_valid` is set, one cycle later.
- R6: On any other `mv_done` with `mv_ti`=1, or with `mv_di`=1 at an input dock, C takes `pkt_signal` and `c_valid` is set.
- R7: On any remaining `mv_done`, C is driven to 0 and `c_valid` is cleared.
- R8: A `setf_valid` whose selectors read C (bit4 or bit5 set in either field), when the last instruction event was a move, pulses `err_c_race` for one cycle, one cycle later. The events that end a move's window are a set-flags or `ins_done`.
- R9: A `mv_done` with `mv_immune`=0, `mv_ti`=0 and `mv_di`=0 pulses `err_torp` one cycle later.
- R10: After reset, A, B, C, `c_valid`, `dec_valid` and both error outputs are 0. A and B change only on `setf_valid`, and C changes only on `mv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_valid | input | 1 | Evaluate the predicate this cycle |
| pred_mask | input | 6 | One-hot skip mask (R1 layout) |
| d_flag | input | 1 | Loop-done flag from the counter logic |
| setf_valid | input | 1 | Set-flags instruction executes |
| setf_sel_a | input | 6 | Literal selector for the new A |
| setf_sel_b | input | 6 | Literal selector for the new B |
| mv_done | input | 1 | A move completes |
| mv_is_output | input | 1 | 1 at an output dock, 0 at an input dock |
| mv_dc | input | 1 | Move takes C from the ship |
| mv_ti | input | 1 | Move waits for a token input |
| mv_di | input | 1 | Move waits for a data input |
| mv_immune | input | 1 | Move cannot be torpedoed |
| pkt_signal | input | 1 | Signal bit of the incoming packet |
| ship_bit | input | 1 | Condition bit supplied by the ship |
| ins_done | input | 1 | Any other instruction completes |
| dec_valid | output | 1 | Skip decision valid |
| dec_skip | output | 1 | 1 = skip the instruction |
| flag_a | output | 1 | A flag |
| flag_b | output | 1 | B flag |
| flag_c | output | 1 | C flag |
| c_valid | output | 1 | C holds a defined value |
| err_c_race | output | 1 | Set-flags read C right after a move |
| err_torp | output | 1 | Torpedoable move without token or data input |

## Verification
Every result of this unit is registered exactly once. The skip decision, the new flags, the C validity and both error pulses therefore all follow their triggering strobe by one clock edge. The bench updates its behavioural model on each rising edge from the inputs held across that edge. It compares every output with the model on the next falling edge, which is one cycle after the stimulus. New inputs are driven just after that comparison, so they never overlap the capturing edge.

// File: rtl/dock_flag_pkg.sv
// Shared constants and types for the dock predicate and flag unit.
// Assumes a fixed six-literal encoding for both predicates and selectors.
package dock_flag_pkg;
    localparam int LIT_W  = 6;
    localparam int PRED_W = 6;

    // Selector literal positions
    localparam int L_A  = 0;
    localparam int L_NA = 1;
    localparam int L_B  = 2;
    localparam int L_NB = 3;
    localparam int L_C  = 4;
    localparam int L_NC = 5;

    // Predicate condition positions
    localparam int P_A  = 0;
    localparam int P_NA = 1;
    localparam int P_B  = 2;
    localparam int P_NB = 3;
    localparam int P_D  = 4;
    localparam int P_ND = 5;

    typedef logic [LIT_W-1:0]  lit_sel_t;
    typedef logic [PRED_W-1:0] pred_mask_t;

    // Selectors that copy a flag onto itself (abort encoding)
    localparam lit_sel_t KEEP_A = lit_sel_t'(1) << L_A;
    localparam lit_sel_t KEEP_B = lit_sel_t'(1) << L_B;

    typedef enum logic [1:0] {
        CSRC_SHIP = 2'd0,
        CSRC_PKT  = 2'd1,
        CSRC_NONE = 2'd2
    } c_src_e;
endpackage

// File: rtl/dfu_pred_eval.sv
// Predicate evaluator: builds the six conditions from A, B and D, masks them
// with the one-hot skip mask and registers the skip decision.
// Assumes the flags given are the values held before any same-cycle update.
module dfu_pred_eval
    import dock_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       valid_i,
    input  pred_mask_t mask_i,
    input  logic       a_i,
    input  logic       b_i,
    input  logic       d_i,
    output logic       dec_valid_o,
    output logic       dec_skip_o
);
    pred_mask_t cond;
    logic       skip_now;

    // Condition vector in mask bit order
    always_comb begin
        cond       = '0;
        cond[P_A]  = a_i;
        cond[P_NA] = ~a_i;
        cond[P_B]  = b_i;
        cond[P_NB] = ~b_i;
        cond[P_D]  = d_i;
        cond[P_ND] = ~d_i;
    end

    // Skip when any selected condition holds
    assign skip_now = |(cond & mask_i);

    // Register the decision one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid_o <= 1'b0;
            dec_skip_o  <= 1'b0;
        end else begin
            dec_valid_o <= valid_i;
            dec_skip_o  <= valid_i & skip_now;
        end
    end
endmodule

// File: rtl/dfu_literal_or.sv
// Truth-table flag function: OR of the literals picked by a selector.
// Purely combinational; an empty selector yields 0.
module dfu_literal_or
    import dock_flag_pkg::*;
#(
    parameter int N = LIT_W
) (
    input  logic [N-1:0] sel_i,
    input  logic [N-1:0] lit_i,
    output logic         val_o
);
    logic [N-1:0] term;

    // One AND gate per literal
    for (genvar i = 0; i < N; i++) begin : g_term
        assign term[i] = sel_i[i] & lit_i[i];
    end

    // Reduce the selected literals
    assign val_o = |term;
endmodule

// File: rtl/dfu_c_select.sv
// Chooses where a completed move takes its C value from.
// Ship source wins at an output dock with Dc; then packet signal; else none.
module dfu_c_select
    import dock_flag_pkg::*;
(
    input  logic   is_output_i,
    input  logic   dc_i,
    input  logic   ti_i,
    input  logic   di_i,
    output c_src_e src_o
);
    // Priority selection of the C source
    always_comb begin
        if (is_output_i && dc_i) begin
            src_o = CSRC_SHIP;
        end else if (ti_i || (di_i && !is_output_i)) begin
            src_o = CSRC_PKT;
        end else begin
            src_o = CSRC_NONE;
        end
    end
endmodule

// File: rtl/dfu_hazard.sv
// Detects illegal instruction sequences: a C-reading set-flags straight
// after a move, and a torpedoable move with neither input enabled.
// Assumes at most one instruction-completion strobe pair per cycle.
module dfu_hazard
    import dock_flag_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     setf_i,
    input  lit_sel_t sel_a_i,
    input  lit_sel_t sel_b_i,
    input  logic     mv_i,
    input  logic     immune_i,
    input  logic     ti_i,
    input  logic     di_i,
    input  logic     other_i,
    output logic     err_c_o,
    output logic     err_t_o
);
    logic after_move;
    logic reads_c;

    // Does either selector touch the C literals
    assign reads_c = sel_a_i[L_C] | sel_a_i[L_NC] | sel_b_i[L_C] | sel_b_i[L_NC];

    // Track whether the latest instruction event was a move
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            after_move <= 1'b0;
        end else if (mv_i) begin
            after_move <= 1'b1;
        end else if (setf_i || other_i) begin
            after_move <= 1'b0;
        end
    end

    // Register one-cycle error pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_c_o <= 1'b0;
            err_t_o <= 1'b0;
        end else begin
            err_c_o <= setf_i & reads_c & after_move;
            err_t_o <= mv_i & ~immune_i & ~ti_i & ~di_i;
        end
    end
endmodule

// File: rtl/dock_flag_unit.sv
// Dock predicate and flag unit: holds A, B, C and C validity, evaluates the
// skip predicate and flags illegal sequences. Decoding lives outside.
// Assumes all strobes are synchronous to clk and single-cycle.
module dock_flag_unit
    import dock_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pred_valid,
    input  logic [5:0] pred_mask,
    input  logic       d_flag,
    input  logic       setf_valid,
    input  logic [5:0] setf_sel_a,
    input  logic [5:0] setf_sel_b,
    input  logic       mv_done,
    input  logic       mv_is_output,
    input  logic       mv_dc,
    input  logic       mv_ti,
    input  logic       mv_di,
    input  logic       mv_immune,
    input  logic       pkt_signal,
    input  logic       ship_bit,
    input  logic       ins_done,
    output logic       dec_valid,
    output logic       dec_skip,
    output logic       flag_a,
    output logic       flag_b,
    output logic       flag_c,
    output logic       c_valid,
    output logic       err_c_race,
    output logic       err_torp
);
    logic     a_q, b_q, c_q, cv_q;
    lit_sel_t lits;
    logic     a_new, b_new;
    c_src_e   c_src;

    // Literal vector in selector bit order, from pre-update flags
    always_comb begin
        lits       = '0;
        lits[L_A]  = a_q;
        lits[L_NA] = ~a_q;
        lits[L_B]  = b_q;
        lits[L_NB] = ~b_q;
        lits[L_C]  = c_q;
        lits[L_NC] = ~c_q;
    end

    dfu_pred_eval u_pred (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (pred_valid),
        .mask_i     (pred_mask),
        .a_i        (a_q),
        .b_i        (b_q),
        .d_i        (d_flag),
        .dec_valid_o(dec_valid),
        .dec_skip_o (dec_skip)
    );

    dfu_literal_or #(.N(LIT_W)) u_or_a (
        .sel_i(setf_sel_a),
        .lit_i(lits),
        .val_o(a_new)
    );

    dfu_literal_or #(.N(LIT_W)) u_or_b (
        .sel_i(setf_sel_b),
        .lit_i(lits),
        .val_o(b_new)
    );

    dfu_c_select u_csel (
        .is_output_i(mv_is_output),
        .dc_i       (mv_dc),
        .ti_i       (mv_ti),
        .di_i       (mv_di),
        .src_o      (c_src)
    );

    dfu_hazard u_haz (
        .clk     (clk),
        .rst_n   (rst_n),
        .setf_i  (setf_valid),
        .sel_a_i (setf_sel_a),
        .sel_b_i (setf_sel_b),
        .mv_i    (mv_done),
        .immune_i(mv_immune),
        .ti_i    (mv_ti),
        .di_i    (mv_di),
        .other_i (ins_done),
        .err_c_o (err_c_race),
        .err_t_o (err_torp)
    );

    // A and B update together on set-flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else if (setf_valid) begin
            a_q <= a_new;
            b_q <= b_new;
        end
    end

    // C and its validity update on move completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q  <= 1'b0;
            cv_q <= 1'b0;
        end else if (mv_done) begin
            case (c_src)
                CSRC_SHIP: begin c_q <= ship_bit;   cv_q <= 1'b1; end
                CSRC_PKT:  begin c_q <= pkt_signal; cv_q <= 1'b1; end
                default:   begin c_q <= 1'b0;       cv_q <= 1'b0; end
            endcase
        end
    end

    assign flag_a  = a_q;
    assign flag_b  = b_q;
    assign flag_c  = c_q;
    assign c_valid = cv_q;
endmodule

// File: rtl/dock_flag_unit_chk.sv
// Property checker for dock_flag_unit, attached by bind below.
module dock_flag_unit_chk
    import dock_flag_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pred_valid,
    input logic [5:0] pred_mask,
    input logic       setf_valid,
    input logic [5:0] setf_sel_a,
    input logic [5:0] setf_sel_b,
    input logic       mv_done,
    input logic       mv_is_output,
    input logic       mv_dc,
    input logic       mv_ti,
    input logic       mv_di,
    input logic       mv_immune,
    input logic       ship_bit,
    input logic       dec_valid,
    input logic       dec_skip,
    input logic       flag_a,
    input logic       flag_b,
    input logic       flag_c,
    input logic       c_valid,
    input logic       err_torp
);
    p_skip_on_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid && pred_mask[P_A] && flag_a |=> dec_valid && dec_skip);

    p_empty_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid && pred_mask == '0 |=> dec_valid && !dec_skip);

    p_empty_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
        setf_valid && setf_sel_a == '0 |=> !flag_a);

    p_abort_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        setf_valid && setf_sel_a == KEEP_A && setf_sel_b == KEEP_B
        |=> flag_a == $past(flag_a) && flag_b == $past(flag_b));

    p_ship_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mv_done && mv_is_output && mv_dc |=> c_valid && flag_c == $past(ship_bit));

    p_no_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mv_done && !(mv_is_output && mv_dc) && !mv_ti && !(mv_di && !mv_is_output)
        |=> !c_valid && !flag_c);

    p_torp_error_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mv_done && !mv_immune && !mv_ti && !mv_di |=> err_torp);

    p_ab_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !setf_valid |=> $stable(flag_a) && $stable(flag_b));

    p_c_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mv_done |=> $stable(flag_c) && $stable(c_valid));
endmodule

bind dock_flag_unit dock_flag_unit_chk u_chk (.*);

// File: tb/dock_flag_unit_bench.sv
// Self-checking bench with a behavioural reference model compared each cycle.
module dock_flag_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pred_valid, d_flag, setf_valid, mv_done, mv_is_output;
    logic       mv_dc, mv_ti, mv_di, mv_immune, pkt_signal, ship_bit, ins_done;
    logic [5:0] pred_mask, setf_sel_a, setf_sel_b;
    logic       dec_valid, dec_skip, flag_a, flag_b, flag_c, c_valid;
    logic       err_c_race, err_torp;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference model state
    logic  m_a, m_b, m_c, m_cv, m_after_mv, m_dv, m_skip, m_ec, m_et;
    string m_ab_req, m_c_req, m_skip_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    dock_flag_unit u_dock_flag_unit (.*);

    function automatic logic lit_val(int i, logic a, logic b, logic c);
        case (i)
            0: return a;
            1: return !a;
            2: return b;
            3: return !b;
            4: return c;
            default: return !c;
        endcase
    endfunction

    function automatic logic or_sel(logic [5:0] sel, logic a, logic b, logic c);
        logic r = 1'b0;
        for (int i = 0; i < 6; i++) if (sel[i] && lit_val(i, a, b, c)) r = 1'b1;
        return r;
    endfunction

    // Reference model, updated on the capturing edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_a <= 0; m_b <= 0; m_c <= 0; m_cv <= 0; m_after_mv <= 0;
            m_dv <= 0; m_skip <= 0; m_ec <= 0; m_et <= 0;
            m_ab_req <= "R10"; m_c_req <= "R10"; m_skip_req <= "R10";
        end else begin
            m_dv   <= pred_valid;
            m_skip <= pred_valid && ((pred_mask[0] && m_a) || (pred_mask[1] && !m_a) ||
                                     (pred_mask[2] && m_b) || (pred_mask[3] && !m_b) ||
                                     (pred_mask[4] && d_flag) || (pred_mask[5] && !d_flag));
            m_skip_req <= (pred_mask == 0) ? "R2" : "R1";
            if (setf_valid) begin
                m_a <= or_sel(setf_sel_a, m_a, m_b, m_c);
                m_b <= or_sel(setf_sel_b, m_a, m_b, m_c);
                m_ab_req <= (setf_sel_a == 0 || setf_sel_b == 0 ||
                             (setf_sel_a == 6'b000001 && setf_sel_b == 6'b000100)) ? "R4" : "R3";
            end else begin
                m_ab_req <= "R10";
            end
            if (mv_done) begin
                if (mv_is_output && mv_dc) begin
                    m_c <= ship_bit; m_cv <= 1; m_c_req <= "R5";
                end else if (mv_ti || (mv_di && !mv_is_output)) begin
                    m_c <= pkt_signal; m_cv <= 1; m_c_req <= "R6";
                end else begin
                    m_c <= 0; m_cv <= 0; m_c_req <= "R7";
                end
            end else begin
                m_c_req <= "R10";
            end
            m_ec <= setf_valid && m_after_mv && ((setf_sel_a[5:4] != 0) || (setf_sel_b[5:4] != 0));
            m_et <= mv_done && !mv_immune && !mv_ti && !mv_di;
            if (mv_done) m_after_mv <= 1;
            else if (setf_valid || ins_done) m_after_mv <= 0;
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output on the falling edge, one cycle after stimulus
    always @(negedge clk) begin
        if (!done) begin
            chk("R1", "dec_valid", dec_valid, m_dv);
            chk(m_skip_req, "dec_skip", dec_skip, m_skip);
            chk(m_ab_req, "flag_a", flag_a, m_a);
            chk(m_ab_req, "flag_b", flag_b, m_b);
            chk(m_c_req, "flag_c", flag_c, m_c);
            chk(m_c_req, "c_valid", c_valid, m_cv);
            chk("R8", "err_c_race", err_c_race, m_ec);
            chk("R9", "err_torp", err_torp, m_et);
        end
    end

    task automatic idle();
        pred_valid = 0; pred_mask = 0; d_flag = 0; setf_valid = 0;
        setf_sel_a = 0; setf_sel_b = 0; mv_done = 0; mv_is_output = 0;
        mv_dc = 0; mv_ti = 0; mv_di = 0; mv_immune = 1; pkt_signal = 0;
        ship_bit = 0; ins_done = 0;
    endtask

    // Advance to just after the next comparison point, then clear inputs
    task automatic next();
        @(negedge clk); #1;
        idle();
    endtask

    task automatic setf(logic [5:0] sa, logic [5:0] sb);
        setf_valid = 1; setf_sel_a = sa; setf_sel_b = sb;
        next();
    endtask

    task automatic move(logic outd, logic dc, logic ti, logic di, logic imm, logic sig, logic shp);
        mv_done = 1; mv_is_output = outd; mv_dc = dc; mv_ti = ti; mv_di = di;
        mv_immune = imm; pkt_signal = sig; ship_bit = shp;
        next();
    endtask

    task automatic pred(logic [5:0] m, logic d);
        pred_valid = 1; pred_mask = m; d_flag = d;
        next();
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        next();                                         // R10 reset state compared
        setf(6'b000010, 6'b001000);                     // R3: A=!A=1, B=!B=1
        setf(6'b000100, 6'b000001);                     // R3: swap from pre-update values
        setf(6'b000001, 6'b000100);                     // R4: abort keeps flags
        setf(6'b000000, 6'b000100);                     // R4: empty field clears A
        pred(6'b001001, 0);                             // R1: B=1,A=0 -> execute
        pred(6'b000000, 1);                             // R2: never skip
        pred(6'b010000, 1);                             // R1: skip on D
        move(1, 1, 1, 1, 1, 0, 1);                      // R5: ship source
        move(0, 1, 1, 0, 1, 1, 0);                      // R6: Ti at input dock
        move(0, 0, 0, 1, 1, 0, 1);                      // R6: Di at input dock
        move(1, 0, 0, 1, 1, 1, 1);                      // R7: Di at output dock -> none
        move(0, 0, 0, 0, 0, 1, 1);                      // R9 and R7
        move(0, 0, 1, 0, 1, 1, 0);                      // R6 then R8 race
        setf(6'b010000, 6'b000100);
        ins_done = 1; next();
        setf(6'b010000, 6'b000100);                     // R8: no race after other instr
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom;
            pred_valid = r[0]; pred_mask = r[6:1] & {6{r[7]}}; d_flag = r[8];
            setf_valid = r[9] & r[10];
            setf_sel_a = r[11] ? 6'b000001 : r[17:12];
            setf_sel_b = r[11] ? 6'b000100 : r[23:18];
            r = $urandom;
            mv_done = r[0] & ~setf_valid; mv_is_output = r[1]; mv_dc = r[2];
            mv_ti = r[3]; mv_di = r[4]; mv_immune = r[5]; pkt_signal = r[6];
            ship_bit = r[7]; ins_done = r[8] & r[9] & ~mv_done & ~setf_valid;
            next();
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule